// File: doc/BRIEF.md
# Programmable Logic Cell

This block models one configurable logic cell of the kind that is tiled across a programmable fabric. Two 4-input lookup tables, A and B, each give a function of their own four inputs. A third, 3-input merge table M combines the A and B results with one extra signal. That extra signal is picked by configuration from a dedicated auxiliary pin, the data pin or the set/reset pin. Two combinational outputs choose between a first-level table and the merge table. Two storage elements each take their data from the data pin or from one of the three tables. The storage elements share a clock enable and a set/reset line. Each one has its own configured set-or-clear value, and the set/reset line has a configured active level.

All table contents and multiplexer selects come from a 51-bit configuration word. The word is loaded one bit per cycle through a valid/ready stream port, least significant bit first. A bit transfers on a rising clock edge where both `cfg_valid` and `cfg_ready` are high. The source may hold `cfg_valid` low for any number of cycles without losing its place. The cell raises `cfg_ready` from reset until the whole word has been taken. It then drops `cfg_ready` for good and raises `cfg_done`. Until then all four cell outputs stay low. An active-low reset clears the storage elements and restarts loading.

Configuration word layout (bit positions):
- 15:0: table A.
- 31:16: table B.
- 39:32: table M.
- 41:40: M source.
- 43:42: A-side register data select.
- 45:44: B-side register data select.
- 46: A output uses M.
- 47: B output uses M.
- 48: A register set/reset value.
- 49: B register set/reset value.
- 50: set/reset active low.

Top module: `lcell_top`

## Requirements
- R1: A configuration bit is taken on each rising edge where `cfg_valid` and `cfg_ready` are both high, and the first bit taken becomes bit 0. Cycles with `cfg_valid` low do not advance loading. `cfg_ready` stays high and `cfg_done` stays low until 51 bits have been taken. After that `cfg_ready` is low and `cfg_done` is high until reset.
- R2: While `cfg_done` is low, `out_a`, `out_b`, `q_a` and `q_b` are all 0.
- R3: Table A's result is bit `a_in` of the word (bits 15:0, with `a_in[0]` as the index LSB). Table B's result is bit 16+`b_in` of the word.
- R4: The merge result is word bit 32 + {s, B, A}, with s as the MSB and A as the LSB. The source s is chosen by bits 41:40: 0 and 3 select `aux_in`, 1 selects `data_in`, and 2 selects the raw `setrst` pin.
- R5: `out_a` is the merge result when bit 46 is 1 and table A's result otherwise. `out_b` is the merge result when bit 47 is 1 and table B's result otherwise.
- R6: Each register's data select (bits 43:42 for A, 45:44 for B) picks, by value: 0 `data_in`, 1 table A, 2 table B, 3 merge. On a rising edge with `clk_en` high and set/reset inactive, `q_a` and `q_b` take their selected data.
- R7: On a rising edge with `clk_en` low and set/reset inactive, `q_a` and `q_b` keep their values.
- R8: Set/reset is active when `setrst` equals 1 and bit 50 is 0, or when `setrst` equals 0 and bit 50 is 1. While it is active, `q_a` equals bit 48 and `q_b` equals bit 49, at once and without a clock edge, whatever `clk_en` is.
- R9: Bits offered on `cfg_valid` after `cfg_done` is high are ignored, and the loaded function is unchanged.
- R10: `rst_n` low at once clears `q_a` and `q_b`, drops `cfg_done`, raises `cfg_ready` and restarts loading at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration bit offered |
| cfg_bit | input | 1 | Configuration bit value |
| cfg_ready | output | 1 | Cell accepts a configuration bit |
| cfg_done | output | 1 | Full configuration word loaded |
| a_in | input | 4 | Table A inputs |
| b_in | input | 4 | Table B inputs |
| aux_in | input | 1 | Dedicated merge-table input |
| data_in | input | 1 | Direct register data, optional merge input |
| setrst | input | 1 | Shared set/reset, optional merge input |
| clk_en | input | 1 | Shared register clock enable |
| out_a | output | 1 | Combinational output A |
| out_b | output | 1 | Combinational output B |
| q_a | output | 1 | Registered output A |
| q_b | output | 1 | Registered output B |

## Verification
The assertions check on every cycle that loading stops at the word length and that the word stays frozen once done. They also check that outputs are low before loading completes. For each register they check that an active set/reset forces the configured value, that a disabled register holds, and that an enabled one captures its data. The truth of the table functions, the LSB-first bit order, the M-source and output selects, and both set/reset polarities can only be shown by the bench. It loads random words covering every M source and both polarities, then sweeps every input combination against an arithmetic model.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int LUT_IN  = 4;
  localparam int LUT_LEN = 1 << LUT_IN;
  localparam int M_IN    = 3;
  localparam int M_LEN   = 1 << M_IN;
  localparam int N_REG   = 2;

  localparam logic [1:0] DSEL_DATA = 2'd0;
  localparam logic [1:0] DSEL_A    = 2'd1;
  localparam logic [1:0] DSEL_B    = 2'd2;
  localparam logic [1:0] DSEL_M    = 2'd3;

  localparam logic [1:0] MSRC_AUX  = 2'd0;
  localparam logic [1:0] MSRC_DATA = 2'd1;
  localparam logic [1:0] MSRC_SR   = 2'd2;

  typedef struct packed {
    logic               sr_low;
    logic               qb_sr_val;
    logic               qa_sr_val;
    logic               ob_use_m;
    logic               oa_use_m;
    logic [1:0]         qb_dsel;
    logic [1:0]         qa_dsel;
    logic [1:0]         m_src;
    logic [M_LEN-1:0]   m_tab;
    logic [LUT_LEN-1:0] b_tab;
    logic [LUT_LEN-1:0] a_tab;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int N = 4,
  localparam int LEN = 1 << N
) (
  input  logic [LEN-1:0] tab,
  input  logic [N-1:0]   idx,
  output logic           y
);
  assign y = tab[idx];
endmodule

// File: rtl/lcell_cfg_shift.sv
module lcell_cfg_shift #(
  parameter int W = 51,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         bit_in,
  output logic         ready,
  output logic         done,
  output logic [W-1:0] word
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  sreg;

  assign done  = (cnt == CW'(W));
  assign ready = !done;
  assign word  = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sreg <= '0;
    end else if (valid && ready) begin
      sreg <= {bit_in, sreg[W-1:1]};
      cnt  <= cnt + 1'b1;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(W));
  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
  // R9
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> $stable(sreg));
endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_act,
  input  logic sr_val,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n or posedge sr_act) begin
    if (!rst_n)      q <= 1'b0;
    else if (sr_act) q <= sr_val;
    else if (en)     q <= d;
  end

  // R8
  sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n) sr_act |-> (q == sr_val));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sr_act) |=> (sr_act || $stable(q)));
  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sr_act) |=> (sr_act || q == $past(d)));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic       cfg_bit,
  output logic       cfg_ready,
  output logic       cfg_done,
  input  logic [3:0] a_in,
  input  logic [3:0] b_in,
  input  logic       aux_in,
  input  logic       data_in,
  input  logic       setrst,
  input  logic       clk_en,
  output logic       out_a,
  output logic       out_b,
  output logic       q_a,
  output logic       q_b
);
  logic [CFG_W-1:0] cfg_word;
  cell_cfg_t        cfg;
  logic             a_res, b_res, m_res, m_sel_in, sr_act;
  logic [N_REG-1:0] reg_q, reg_sr_val;
  logic [1:0]       reg_dsel [N_REG];

  lcell_cfg_shift #(.W(CFG_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .valid(cfg_valid), .bit_in(cfg_bit),
    .ready(cfg_ready), .done(cfg_done), .word(cfg_word)
  );
  assign cfg = cell_cfg_t'(cfg_word);

  lcell_lut #(.N(LUT_IN)) i_lut_a (.tab(cfg.a_tab), .idx(a_in), .y(a_res));
  lcell_lut #(.N(LUT_IN)) i_lut_b (.tab(cfg.b_tab), .idx(b_in), .y(b_res));

  always_comb begin
    unique case (cfg.m_src)
      MSRC_DATA: m_sel_in = data_in;
      MSRC_SR:   m_sel_in = setrst;
      default:   m_sel_in = aux_in;
    endcase
  end

  lcell_lut #(.N(M_IN)) i_lut_m (.tab(cfg.m_tab), .idx({m_sel_in, b_res, a_res}), .y(m_res));

  assign sr_act        = cfg_done && (setrst ^ cfg.sr_low);
  assign reg_dsel[0]   = cfg.qa_dsel;
  assign reg_dsel[1]   = cfg.qb_dsel;
  assign reg_sr_val    = {cfg.qb_sr_val, cfg.qa_sr_val};

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic d_pick;
    always_comb begin
      unique case (reg_dsel[i])
        DSEL_A:  d_pick = a_res;
        DSEL_B:  d_pick = b_res;
        DSEL_M:  d_pick = m_res;
        default: d_pick = data_in;
      endcase
    end
    lcell_reg i_reg (
      .clk(clk), .rst_n(rst_n), .sr_act(sr_act), .sr_val(reg_sr_val[i]),
      .en(clk_en && cfg_done), .d(d_pick), .q(reg_q[i])
    );
  end

  assign out_a = cfg_done && (cfg.oa_use_m ? m_res : a_res);
  assign out_b = cfg_done && (cfg.ob_use_m ? m_res : b_res);
  assign q_a   = cfg_done && reg_q[0];
  assign q_b   = cfg_done && reg_q[1];

  // R2
  held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> ({out_a, out_b, q_a, q_b} == 4'b0000));
endmodule

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;
  localparam int W = 51;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_valid, cfg_bit, cfg_ready, cfg_done;
  logic [3:0] a_in, b_in;
  logic aux_in, data_in, setrst, clk_en;
  logic out_a, out_b, q_a, q_b;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  lcell_top i_lcell_top (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_ready(cfg_ready), .cfg_done(cfg_done), .a_in(a_in), .b_in(b_in),
    .aux_in(aux_in), .data_in(data_in), .setrst(setrst), .clk_en(clk_en),
    .out_a(out_a), .out_b(out_b), .q_a(q_a), .q_b(q_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // returns {d_b, d_a, y_b, y_a}
  function automatic logic [3:0] model(input logic [W-1:0] c, input logic [3:0] a, b,
                                       input logic aux, dat, s);
    logic av, bv, sel, mv;
    logic [1:0] dsa, dsb;
    logic [3:0] src;
    av  = c[a];
    bv  = c[16 + b];
    sel = (c[41:40] == 2'd1) ? dat : (c[41:40] == 2'd2) ? s : aux;
    mv  = c[32 + {sel, bv, av}];
    src = {mv, bv, av, dat};
    dsa = c[43:42];
    dsb = c[45:44];
    return {src[dsb], src[dsa], c[47] ? mv : bv, c[46] ? mv : av};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_valid = 1'b0;
    #1;
    check("R10 q_a cleared", q_a, 0);
    check("R10 q_b cleared", q_b, 0);
    check("R10 cfg_ready", cfg_ready, 1);
    check("R10 cfg_done", cfg_done, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bits(input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) begin
        cfg_valid = 1'b0;
        cfg_bit = ~v[i];
        @(negedge clk);
      end
      cfg_valid = 1'b1;
      cfg_bit = v[i];
      @(posedge clk);
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic check_comb(input logic [W-1:0] c, input string tag);
    logic [3:0] e;
    #1;
    e = model(c, a_in, b_in, aux_in, data_in, setrst);
    check({tag, " R3/R4/R5 out_a"}, out_a, e[0]);
    check({tag, " R3/R4/R5 out_b"}, out_b, e[1]);
  endtask

  task automatic run_cfg(input logic [W-1:0] c);
    logic idle;
    logic [3:0] e;
    logic pa, pb;
    idle = c[50];
    do_reset();
    send_bits(c, W);
    check("R1 cfg_done after word", cfg_done, 1);
    check("R1 cfg_ready after word", cfg_ready, 0);
    // exhaustive combinational sweep
    for (int k = 0; k < 2048; k++) begin
      {setrst, data_in, aux_in, b_in, a_in} = 11'(k);
      check_comb(c, "sweep");
    end
    // registered capture
    setrst = idle;
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      {data_in, aux_in, b_in, a_in} = 10'($urandom);
      clk_en = 1'b1;
      e = model(c, a_in, b_in, aux_in, data_in, setrst);
      @(posedge clk); #1;
      check("R6 q_a capture", q_a, e[2]);
      check("R6 q_b capture", q_b, e[3]);
      // hold with enable low
      @(negedge clk);
      pa = q_a; pb = q_b;
      {data_in, aux_in, b_in, a_in} = 10'($urandom);
      clk_en = 1'b0;
      @(posedge clk); #1;
      check("R7 q_a hold", q_a, pa);
      check("R7 q_b hold", q_b, pb);
      @(negedge clk);
    end
    // asynchronous set/reset
    clk_en = 1'b1;
    setrst = ~idle;
    #1;
    check("R8 q_a forced async", q_a, c[48]);
    check("R8 q_b forced async", q_b, c[49]);
    @(posedge clk); #1;
    check("R8 q_a forced over enable", q_a, c[48]);
    check("R8 q_b forced over enable", q_b, c[49]);
    @(negedge clk);
    setrst = idle;
    // bits after done are ignored
    send_bits(~c, 8);
    check("R9 cfg_ready stays low", cfg_ready, 0);
    for (int k = 0; k < 16; k++) begin
      {data_in, aux_in, b_in, a_in} = 10'($urandom);
      check_comb(c, "R9 after extra bits");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [W-1:0] c;
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_bit = 1'b0;
    a_in = '0; b_in = '0; aux_in = 0; data_in = 0; setrst = 0; clk_en = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R10 reset cfg_ready", cfg_ready, 1);
    check("R10 reset cfg_done", cfg_done, 0);
    rst_n = 1'b1;
    // partial load with stalls: outputs held low
    c = {$urandom, $urandom};
    send_bits(c, 20);
    repeat (5) @(negedge clk);
    check("R1 not done after 20 bits", cfg_done, 0);
    check("R1 still ready", cfg_ready, 1);
    for (int k = 0; k < 16; k++) begin
      {setrst, clk_en, data_in, aux_in, b_in, a_in} = 12'($urandom);
      @(posedge clk); #1;
      check("R2 out_a low", out_a, 0);
      check("R2 out_b low", out_b, 0);
      check("R2 q_a low", q_a, 0);
      check("R2 q_b low", q_b, 0);
      @(negedge clk);
    end
    setrst = 0;
    for (int n = 0; n < 8; n++) begin
      c = {$urandom, $urandom};
      c[41:40] = 2'(n % 4);
      c[50] = n[2];
      run_cfg(c);
    end
    summary();
  end
endmodule